// File: doc/BRIEF.md
# Clock-master audio bit clock and frame sync generator

This block is the timing source of a serial audio port that runs as clock master. It divides a reference clock into a bit clock and then counts bit clocks to produce a frame sync. The width of the frame sync depends on the selected framing style: half the frame for I2S and left-justified framing, a single bit clock for the two DSP styles. DSP-A and DSP-B produce identical frame sync here. Their difference is the data delay, and the shift logic applies it. Alongside the pins, the block gives one-cycle strobes in the reference domain. They mark where transmit data is launched and where receive data is sampled, so the shifters can run on the reference clock.

The configuration is taken from the inputs on every reference cycle in which the enable is low. It is held unchanged while the enable is high. The configuration is the divisor, the frame length, the word length and channel count, the framing style and two polarity inverts. When the enable rises, the block starts from the beginning of a frame. A frame length of zero, or one shorter than word length times channel count, raises the error flag and keeps the block idle.

Top module: `audio_sync_gen`

## Requirements
- R1: While reset is high, `cfg_err` is 0, `bclk` is 0, `fsync` is 1 and both strobes are 0.
- R2: Each bit-clock phase (high or low) lasts D reference cycles, where D is `clk_div`, and a `clk_div` of 0 acts as 1. The nominal bit clock is low when idle and goes high D cycles after the enable is first seen.
- R3: `sample_stb` is high for exactly the one cycle in which the nominal bit clock has just gone high. `launch_stb` is high for exactly the one cycle in which it has just gone low.
- R4: A frame lasts `frame_len` bit clocks, measured between falling edges of the nominal bit clock. The first frame starts with the first bit clock after the enable rises.
- R5: For `fmt` 0 (I2S) and 1 (left-justified), the frame sync is active for the first floor(`frame_len`/2) bit clocks of each frame.
- R6: For `fmt` 2 (DSP-A) and 3 (DSP-B), the frame sync is active for only the first bit clock of each frame.
- R7: The active level of `fsync` is high when (`fmt` is not 0) XOR `fs_inv` is 1, and low otherwise. When idle, `fsync` sits at its inactive level.
- R8: `bclk_inv` = 1 inverts the `bclk` pin, including its idle level. The strobes are unaffected.
- R9: `cfg_err` is 1 when `frame_len` is 0 or less than `word_len` × `chan_cnt`. While it is 1, a high enable produces no bit-clock edges, no strobes and no frame sync.
- R10: Changes to any configuration input while `en` is high have no effect on the outputs until `en` has been low for a cycle.
- R11: Dropping and raising `en` again restarts the bit-clock and frame counters from the beginning of a frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; configuration is loaded while low |
| clk_div | input | DIV_W | Reference cycles per bit-clock phase (0 treated as 1) |
| frame_len | input | LEN_W | Frame length in bit clocks |
| word_len | input | WL_W | Bits per word, used for the length check |
| chan_cnt | input | CH_W | Channels per frame, used for the length check |
| fmt | input | 2 | Framing style: 0 I2S, 1 left-justified, 2 DSP-A, 3 DSP-B |
| fs_inv | input | 1 | Inverts the frame sync active level |
| bclk_inv | input | 1 | Inverts the bit clock pin |
| bclk | output | 1 | Bit clock |
| fsync | output | 1 | Frame sync |
| launch_stb | output | 1 | One-cycle strobe at the nominal falling bit-clock edge |
| sample_stb | output | 1 | One-cycle strobe at the nominal rising bit-clock edge |
| cfg_err | output | 1 | Frame length too short for the payload, or zero |

## Verification
The main function is tried with random divisors (including 0 and 1), random word and channel counts, and frame lengths both equal to the payload and above it. Lengths are odd and even, so the floor in the half-frame width shows up. All four framing styles are combined with every polarity invert. Odd lengths separate a correct half-width from one rounded up. DSP runs separate a one-bit pulse from a half-frame pulse. A zero divisor separates the clamp from a wrap-around count. Runs whose inputs are changed midway show whether the configuration is truly held. Back-to-back runs show the restart. Lengths just below the payload, and a length of zero, exercise the error path.

// File: rtl/asg_pkg.sv
package asg_pkg;
  typedef enum logic [1:0] {
    FMT_I2S  = 2'd0,
    FMT_LEFT = 2'd1,
    FMT_DSPA = 2'd2,
    FMT_DSPB = 2'd3
  } sync_fmt_e;
endpackage

// File: rtl/asg_bit_div.sv
module asg_bit_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] last,
  input  logic             inv,
  output logic             bclk_o,
  output logic             rise_o,
  output logic             fall_o,
  output logic             fall_tick
);
  logic [DIV_W-1:0] pc;
  logic             ph;
  logic             tick;

  always_comb begin
    tick      = run && (pc == last);
    fall_tick = tick && ph;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc     <= '0;
      ph     <= 1'b0;
      bclk_o <= 1'b0;
      rise_o <= 1'b0;
      fall_o <= 1'b0;
    end else if (!run) begin
      pc     <= '0;
      ph     <= 1'b0;
      bclk_o <= inv;
      rise_o <= 1'b0;
      fall_o <= 1'b0;
    end else begin
      pc     <= tick ? '0 : pc + 1'b1;
      if (tick) ph <= ~ph;
      bclk_o <= (ph ^ tick) ^ inv;
      rise_o <= tick & ~ph;
      fall_o <= tick & ph;
    end
  end

  p_div_range_r2: assert property (@(posedge clk) disable iff (rst)
    run |-> pc <= last);
  p_strobe_excl_r3: assert property (@(posedge clk) disable iff (rst)
    rise_o |-> !fall_o);
  p_rise_edge_r3: assert property (@(posedge clk) disable iff (rst)
    rise_o |-> ph && !$past(ph));
  p_fall_edge_r3: assert property (@(posedge clk) disable iff (rst)
    fall_o |-> !ph && $past(ph));
endmodule

// File: rtl/asg_frame_cnt.sv
module asg_frame_cnt #(
  parameter int LEN_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             adv,
  input  logic [LEN_W-1:0] last_bit,
  input  logic [LEN_W-1:0] width,
  input  logic             act_hi,
  output logic             fs_o
);
  logic [LEN_W-1:0] bc;
  logic [LEN_W-1:0] bc_n;
  logic             act_q;

  always_comb begin
    bc_n = bc;
    if (adv) bc_n = (bc == last_bit) ? '0 : bc + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bc    <= '0;
      act_q <= 1'b0;
      fs_o  <= 1'b1;
    end else if (!run) begin
      bc    <= '0;
      act_q <= 1'b0;
      fs_o  <= ~act_hi;
    end else begin
      bc    <= bc_n;
      act_q <= (bc_n < width);
      fs_o  <= ~((bc_n < width) ^ act_hi);
    end
  end

  p_bc_range_r4: assert property (@(posedge clk) disable iff (rst)
    run |-> bc <= last_bit);
  p_dsp_one_bit_r6: assert property (@(posedge clk) disable iff (rst)
    run && width == LEN_W'(1) && act_q |-> bc == '0);
endmodule

// File: rtl/audio_sync_gen.sv
module audio_sync_gen
  import asg_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int LEN_W = 10,
  parameter int WL_W  = 6,
  parameter int CH_W  = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [DIV_W-1:0] clk_div,
  input  logic [LEN_W-1:0] frame_len,
  input  logic [WL_W-1:0]  word_len,
  input  logic [CH_W-1:0]  chan_cnt,
  input  logic [1:0]       fmt,
  input  logic             fs_inv,
  input  logic             bclk_inv,
  output logic             bclk,
  output logic             fsync,
  output logic             launch_stb,
  output logic             sample_stb,
  output logic             cfg_err
);
  localparam int NEED_W = WL_W + CH_W;
  localparam int CMP_W  = (LEN_W > NEED_W) ? LEN_W : NEED_W;

  logic [DIV_W-1:0] div_s;
  logic [LEN_W-1:0] len_s;
  sync_fmt_e        fmt_s;
  logic             fsinv_s, bcinv_s;
  logic [CMP_W-1:0] need;
  logic             bad_cfg;
  logic             run;
  logic [DIV_W-1:0] div_last;
  logic [LEN_W-1:0] bit_last;
  logic [LEN_W-1:0] fs_width;
  logic             act_hi;
  logic             fall_tick;

  always_comb begin
    need     = CMP_W'(word_len) * CMP_W'(chan_cnt);
    bad_cfg  = (frame_len == '0) || (CMP_W'(frame_len) < need);
    run      = en && !cfg_err;
    div_last = (div_s == '0) ? '0 : div_s - 1'b1;
    bit_last = len_s - 1'b1;
    fs_width = (fmt_s == FMT_I2S || fmt_s == FMT_LEFT) ? (len_s >> 1) : LEN_W'(1);
    act_hi   = (fmt_s != FMT_I2S) ^ fsinv_s;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      div_s   <= '0;
      len_s   <= '0;
      fmt_s   <= FMT_I2S;
      fsinv_s <= 1'b0;
      bcinv_s <= 1'b0;
      cfg_err <= 1'b0;
    end else if (!en) begin
      div_s   <= clk_div;
      len_s   <= frame_len;
      fmt_s   <= sync_fmt_e'(fmt);
      fsinv_s <= fs_inv;
      bcinv_s <= bclk_inv;
      cfg_err <= bad_cfg;
    end
  end

  asg_bit_div #(.DIV_W(DIV_W)) u_div (
    .clk       (clk),
    .rst       (rst),
    .run       (run),
    .last      (div_last),
    .inv       (bcinv_s),
    .bclk_o    (bclk),
    .rise_o    (sample_stb),
    .fall_o    (launch_stb),
    .fall_tick (fall_tick)
  );

  asg_frame_cnt #(.LEN_W(LEN_W)) u_frame (
    .clk      (clk),
    .rst      (rst),
    .run      (run),
    .adv      (fall_tick),
    .last_bit (bit_last),
    .width    (fs_width),
    .act_hi   (act_hi),
    .fs_o     (fsync)
  );

  p_err_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    cfg_err && en && $past(cfg_err) |-> !launch_stb && !sample_stb);
  p_cfg_hold_r10: assert property (@(posedge clk) disable iff (rst)
    en && $past(en) |-> $stable(len_s) && $stable(div_s) && $stable(fmt_s));
endmodule

// File: tb/test_audio_sync_gen.sv
module test_audio_sync_gen;
  logic       clk = 1'b0;
  logic       rst;
  logic       en;
  logic [7:0] clk_div;
  logic [9:0] frame_len;
  logic [5:0] word_len;
  logic [4:0] chan_cnt;
  logic [1:0] fmt;
  logic       fs_inv, bclk_inv;
  logic       bclk, fsync, launch_stb, sample_stb, cfg_err;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  int m_d, m_p, m_fmt, m_fsi, m_bci;

  always #2 clk = ~clk;

  audio_sync_gen i_audio_sync_gen (
    .clk(clk), .rst(rst), .en(en), .clk_div(clk_div), .frame_len(frame_len),
    .word_len(word_len), .chan_cnt(chan_cnt), .fmt(fmt), .fs_inv(fs_inv),
    .bclk_inv(bclk_inv), .bclk(bclk), .fsync(fsync), .launch_stb(launch_stb),
    .sample_stb(sample_stb), .cfg_err(cfg_err)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      errors = errors + 1;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      errors = errors + 1;
      $display("FAIL %s actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic int act_high();
    return ((m_fmt != 0) ? 1 : 0) ^ m_fsi;
  endfunction
  function automatic int half_idx(int m);
    return m / m_d;
  endfunction
  function automatic int exp_bclk(int m);
    return (half_idx(m) % 2) ^ m_bci;
  endfunction
  function automatic int exp_sample(int m);
    return (m > 0 && m % m_d == 0 && half_idx(m) % 2 == 1) ? 1 : 0;
  endfunction
  function automatic int exp_launch(int m);
    return (m > 0 && m % m_d == 0 && half_idx(m) % 2 == 0) ? 1 : 0;
  endfunction
  function automatic int exp_fsync(int m);
    int b, w, act;
    b   = (half_idx(m) / 2) % m_p;
    w   = (m_fmt < 2) ? m_p / 2 : 1;
    act = (m > 0 && b < w) ? 1 : 0;
    return act_high() != 0 ? act : 1 - act;
  endfunction

  task automatic load(input int d, input int len, input int wl, input int ch,
                      input int f, input int fsi, input int bci);
    clk_div = 8'(d); frame_len = 10'(len); word_len = 6'(wl); chan_cnt = 5'(ch);
    fmt = 2'(f); fs_inv = 1'(fsi); bclk_inv = 1'(bci);
  endtask

  task automatic run_case(input int d, input int len, input int wl, input int ch,
                          input int f, input int fsi, input int bci,
                          input int ncyc, input bit chg, input string ftag);
    @(negedge clk);
    en = 1'b0;
    load(d, len, wl, ch, f, fsi, bci);
    m_d = (d == 0) ? 1 : d; m_p = len; m_fmt = f; m_fsi = fsi; m_bci = bci;
    repeat (3) @(negedge clk);
    check("R9 no error", int'(cfg_err), 0);
    check("R8 idle bclk", int'(bclk), bci);
    check("R7 idle fsync", int'(fsync), 1 - act_high());
    en = 1'b1;
    for (int m = 1; m <= ncyc; m++) begin
      @(negedge clk);
      check(bci != 0 ? "R8 bclk" : "R2 bclk", int'(bclk), exp_bclk(m));
      check("R3 sample", int'(sample_stb), exp_sample(m));
      check("R3 launch", int'(launch_stb), exp_launch(m));
      check(ftag, int'(fsync), exp_fsync(m));
      if (chg && m == ncyc / 3)
        load($urandom_range(0, 5), $urandom_range(0, 40), $urandom_range(1, 8),
             $urandom_range(1, 4), $urandom_range(0, 3), $urandom_range(0, 1),
             $urandom_range(0, 1));
    end
  endtask

  task automatic err_case(input int len, input int wl, input int ch, input int bci);
    @(negedge clk);
    en = 1'b0;
    load(2, len, wl, ch, 0, 0, bci);
    repeat (3) @(negedge clk);
    check("R9 error flag", int'(cfg_err), 1);
    en = 1'b1;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      check("R9 bclk quiet", int'(bclk), bci);
      check("R9 strobes quiet", int'(sample_stb | launch_stb), 0);
      check("R9 fsync quiet", int'(fsync), 1);
    end
  endtask

  initial begin
    void'($urandom(32'h5a17));
    rst = 1'b1; en = 1'b0;
    load(0, 0, 0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    check("R1 reset cfg_err", int'(cfg_err), 0);
    check("R1 reset bclk", int'(bclk), 0);
    check("R1 reset fsync", int'(fsync), 1);
    check("R1 reset strobes", int'(sample_stb | launch_stb), 0);
    rst = 1'b0;

    // directed corners
    run_case(0, 5, 2, 2, 0, 0, 0, 40, 1'b0, "R5 i2s odd len, div0");
    run_case(1, 8, 4, 2, 1, 0, 0, 60, 1'b0, "R5 left-justified");
    run_case(3, 6, 3, 2, 2, 0, 0, 90, 1'b0, "R6 dsp-a");
    run_case(2, 7, 7, 1, 3, 1, 1, 80, 1'b0, "R6 dsp-b inverted");
    run_case(1, 9, 4, 2, 0, 1, 0, 60, 1'b0, "R7 i2s fs_inv");
    run_case(2, 10, 5, 2, 1, 0, 1, 100, 1'b1, "R10 held config");
    run_case(2, 10, 5, 2, 1, 0, 1, 37, 1'b0, "R4 frame");
    run_case(2, 10, 5, 2, 1, 0, 1, 100, 1'b0, "R11 restart");
    err_case(7, 4, 2, 0);
    err_case(0, 1, 1, 1);

    // random configurations
    for (int i = 0; i < 30; i++) begin
      int wl, ch, len, d;
      wl  = $urandom_range(1, 8);
      ch  = $urandom_range(1, 4);
      len = wl * ch + $urandom_range(0, 6);
      if (len < 2) len = 2;
      d   = $urandom_range(0, 4);
      run_case(d, len, wl, ch, $urandom_range(0, 3), $urandom_range(0, 1),
               $urandom_range(0, 1), 4 * len * ((d == 0) ? 1 : d) + 3,
               ($urandom_range(0, 3) == 0), "R4 random frame");
    end
    for (int i = 0; i < 4; i++) begin
      int wl, ch;
      wl = $urandom_range(2, 8);
      ch = $urandom_range(1, 4);
      err_case(wl * ch - 1, wl, ch, $urandom_range(0, 1));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule